// File: doc/BRIEF.md
# System Management RAM Access Controller

This block holds the two control bytes that govern where protected system-management memory becomes visible. The controller turns them into enable flags: one for the legacy low window (0xA0000, length 0x20000) as normal accesses see it, one for the high alias at 0xFEDA0000 that maps the same memory, and two for the privileged view. It also places a protected segment just below the top of low memory. The memory arrays and the address decoders that act on these flags sit outside the block.

Software writes the control bytes through a simple byte-wide port and reads them back on two status buses. A sticky lock bit closes the open window and freezes both bytes until reset. An access filter sits on the path into the protected segment. It checks each access address against the segment. A non-privileged read inside the segment returns all ones, and a non-privileged write there never reaches memory.

Top module: `smram_ctl`

## Requirements
- R1: After reset both control bytes read 0x00, the legacy window is routed to the bus (legacy_bus_en=1), high_alias_en, priv_low_en and priv_high_en are 0, and seg_size is 0.
- R2: The lock bit (basic byte bit 2), once set, stays set until reset, whatever is written afterwards.
- R3: Whenever the lock bit is set, the open bit (basic byte bit 0) reads 0, including on the write that sets the lock together with open.
- R4: While locked, writes to either control byte leave both bytes unchanged.
- R5: With open set, legacy_bus_en equals the inverse of high-enable (extended byte bit 7) and high_alias_en equals high-enable.
- R6: With open clear, legacy_bus_en is 1 and high_alias_en is 0.
- R7: With global-enable (basic byte bit 1) set, priv_low_en = not high-enable and priv_high_en = high-enable; with it clear, both are 0.
- R8: seg_size is decoded from extended byte bits 2:1 when the segment-enable bit (bit 0) is set: 00 gives 1 MiB, 01 gives 2 MiB, 10 gives 8 MiB, 11 gives 0. With segment-enable clear the size is 0.
- R9: seg_base equals tolm minus seg_size.
- R10: A non-privileged access with address in [seg_base, tolm) and a nonzero size sets acc_blocked, returns 0xFFFFFFFF on acc_rdata and holds mem_we low. Any other access passes mem_rdata and acc_we through unchanged.
- R11: cfg_sel=0 writes the basic byte and cfg_sel=1 writes the extended byte. Basic bits 7:3 and extended bits 6:3 always read 0. A write shows on the readback and on all flags at the first clock edge after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_sel | input | 1 | 0 selects the basic byte, 1 the extended byte |
| cfg_wdata | input | 8 | Write data |
| basic_q | output | 8 | Basic control byte readback |
| ext_q | output | 8 | Extended control byte readback |
| tolm | input | 32 | Top of low memory address |
| legacy_bus_en | output | 1 | Normal accesses to the legacy window go to the bus |
| high_alias_en | output | 1 | High alias of the protected memory is visible |
| priv_low_en | output | 1 | Privileged view shows the low window |
| priv_high_en | output | 1 | Privileged view shows the high window |
| seg_base | output | 32 | Base address of the protected top segment |
| seg_size | output | 32 | Size of the protected top segment in bytes |
| acc_addr | input | 32 | Address of the current memory access |
| acc_priv | input | 1 | Current access is privileged |
| acc_we | input | 1 | Current access is a write |
| mem_rdata | input | 32 | Read data returned by memory |
| acc_rdata | output | 32 | Read data returned to the requester |
| mem_we | output | 1 | Write strobe forwarded to memory |
| acc_blocked | output | 1 | Current access falls in the protected segment and is refused |

## Verification
The visibility decode is swept over a vector table that covers open, global-enable and high-enable alone and together. This separates the normal-view flags, which depend on open, from the privileged flags, which depend on global-enable. Every size code is tried with segment-enable set and clear. Unwritable bits are set as well, to show that reserved bits stay 0. Directed cases probe the filter at the first and last word of the segment and just outside both ends, with and without privilege, and with a moved top of memory. The lock tests include setting open in the same write as the lock, attempts to unlock, and attempts to change the extended byte while locked.

// File: rtl/smram_pkg.sv
package smram_pkg;
  // basic byte field positions
  localparam int unsigned BIT_OPEN = 0;
  localparam int unsigned BIT_GEN  = 1;
  localparam int unsigned BIT_LOCK = 2;

  // extended byte layout
  typedef struct packed {
    logic       hen;   // high-enable
    logic [1:0] szc;   // size code
    logic       ten;   // segment enable
  } ext_t;

  typedef enum logic [1:0] {
    SZ_1M  = 2'b00,
    SZ_2M  = 2'b01,
    SZ_8M  = 2'b10,
    SZ_RSV = 2'b11
  } seg_code_e;

  localparam int unsigned MIB_SHIFT = 20;
endpackage

// File: rtl/smram_regs.sv
module smram_regs
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_int_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic       open_q,
  output logic       gen_q,
  output logic       lock_q,
  output ext_t       ext_q
);
  logic open_n, gen_n, lock_n;
  ext_t ext_n;
  logic wr_en;
  logic unused_wbits;

  assign unused_wbits = ^cfg_wdata[6:3];
  // clock enable: no write lands once the lock is held
  assign wr_en = cfg_we & ~lock_q;

  always_comb begin
    open_n = open_q;
    gen_n  = gen_q;
    lock_n = lock_q;
    ext_n  = ext_q;
    if (!cfg_sel) begin
      open_n = cfg_wdata[BIT_OPEN];
      gen_n  = cfg_wdata[BIT_GEN];
      lock_n = cfg_wdata[BIT_LOCK];
    end else begin
      ext_n.hen = cfg_wdata[7];
      ext_n.szc = cfg_wdata[2:1];
      ext_n.ten = cfg_wdata[0];
    end
    if (lock_n) open_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      open_q <= 1'b0;
      gen_q  <= 1'b0;
      lock_q <= 1'b0;
      ext_q  <= '0;
    end else if (wr_en) begin
      open_q <= open_n;
      gen_q  <= gen_n;
      lock_q <= lock_n;
      ext_q  <= ext_n;
    end
  end
endmodule

// File: rtl/smram_view.sv
module smram_view (
  input  logic open_q,
  input  logic gen_q,
  input  logic hen,
  output logic legacy_bus_en,
  output logic high_alias_en,
  output logic priv_low_en,
  output logic priv_high_en
);
  always_comb begin
    if (open_q) begin
      legacy_bus_en = ~hen;
      high_alias_en = hen;
    end else begin
      legacy_bus_en = 1'b1;
      high_alias_en = 1'b0;
    end
    priv_low_en  = gen_q & ~hen;
    priv_high_en = gen_q & hen;
  end
endmodule

// File: rtl/smram_seg.sv
module smram_seg
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  ext_t              ext_q,
  input  logic [ADDR_W-1:0] tolm,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] seg_base,
  output logic [ADDR_W-1:0] seg_size,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              mem_we,
  output logic              acc_blocked
);
  localparam logic [ADDR_W-1:0] ONE_MIB = ADDR_W'(1) << MIB_SHIFT;

  always_comb begin
    seg_size = '0;
    if (ext_q.ten) begin
      unique case (seg_code_e'(ext_q.szc))
        SZ_1M:   seg_size = ONE_MIB;
        SZ_2M:   seg_size = ONE_MIB << 1;
        SZ_8M:   seg_size = ONE_MIB << 3;
        default: seg_size = '0;
      endcase
    end
  end

  assign seg_base = tolm - seg_size;

  logic in_seg;
  assign in_seg      = (seg_size != '0) && (acc_addr >= seg_base) && (acc_addr < tolm);
  assign acc_blocked = in_seg & ~acc_priv;
  assign acc_rdata   = acc_blocked ? '1 : mem_rdata;
  assign mem_we      = acc_we & ~acc_blocked;
endmodule

// File: rtl/smram_ctl.sv
module smram_ctl
  import smram_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        basic_q,
  output logic [7:0]        ext_q,
  input  logic [ADDR_W-1:0] tolm,
  output logic              legacy_bus_en,
  output logic              high_alias_en,
  output logic              priv_low_en,
  output logic              priv_high_en,
  output logic [ADDR_W-1:0] seg_base,
  output logic [ADDR_W-1:0] seg_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_priv,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              mem_we,
  output logic              acc_blocked
);
  // reset: asserts at once, releases on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic open_q, gen_q, lock_q;
  ext_t ext_r;

  smram_regs u_regs (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .open_q    (open_q),
    .gen_q     (gen_q),
    .lock_q    (lock_q),
    .ext_q     (ext_r)
  );

  smram_view u_view (
    .open_q        (open_q),
    .gen_q         (gen_q),
    .hen           (ext_r.hen),
    .legacy_bus_en (legacy_bus_en),
    .high_alias_en (high_alias_en),
    .priv_low_en   (priv_low_en),
    .priv_high_en  (priv_high_en)
  );

  smram_seg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seg (
    .ext_q       (ext_r),
    .tolm        (tolm),
    .acc_addr    (acc_addr),
    .acc_priv    (acc_priv),
    .acc_we      (acc_we),
    .mem_rdata   (mem_rdata),
    .seg_base    (seg_base),
    .seg_size    (seg_size),
    .acc_rdata   (acc_rdata),
    .mem_we      (mem_we),
    .acc_blocked (acc_blocked)
  );

  assign basic_q = {5'b0, lock_q, gen_q, open_q};
  assign ext_q   = {ext_r.hen, 4'b0, ext_r.szc, ext_r.ten};
endmodule

// File: rtl/smram_ctl_chk.sv
module smram_ctl_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        basic_q,
  input logic [7:0]        ext_q,
  input logic [ADDR_W-1:0] tolm,
  input logic              high_alias_en,
  input logic              priv_low_en,
  input logic              priv_high_en,
  input logic [ADDR_W-1:0] seg_base,
  input logic [ADDR_W-1:0] seg_size,
  input logic              acc_priv,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              mem_we,
  input logic              acc_blocked
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    basic_q[2] |=> basic_q[2]); // R2
  AST_LOCK_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    basic_q[2] |-> !basic_q[0]); // R3
  AST_LOCKED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    basic_q[2] |=> ($stable(ext_q) && $stable(basic_q))); // R4
  AST_ALIAS_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    high_alias_en |-> (basic_q[0] && ext_q[7])); // R5
  AST_PRIV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({priv_low_en, priv_high_en})); // R7
  AST_SEG_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_base + seg_size) == tolm); // R9
  AST_BLOCK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_blocked |-> (acc_rdata == '1 && !mem_we)); // R10
  AST_PRIV_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_priv |-> !acc_blocked); // R10
endmodule

bind smram_ctl smram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .basic_q       (basic_q),
  .ext_q         (ext_q),
  .tolm          (tolm),
  .high_alias_en (high_alias_en),
  .priv_low_en   (priv_low_en),
  .priv_high_en  (priv_high_en),
  .seg_base      (seg_base),
  .seg_size      (seg_size),
  .acc_priv      (acc_priv),
  .acc_rdata     (acc_rdata),
  .mem_we        (mem_we),
  .acc_blocked   (acc_blocked)
);

// File: tb/smram_ctl_test.sv
`timescale 1ns/1ps
module smram_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  basic_q, ext_q;
  logic [31:0] tolm;
  logic        legacy_bus_en, high_alias_en, priv_low_en, priv_high_en;
  logic [31:0] seg_base, seg_size;
  logic [31:0] acc_addr;
  logic        acc_priv, acc_we;
  logic [31:0] mem_rdata, acc_rdata;
  logic        mem_we, acc_blocked;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  always #10 clk = ~clk;

  smram_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .basic_q(basic_q), .ext_q(ext_q), .tolm(tolm),
    .legacy_bus_en(legacy_bus_en), .high_alias_en(high_alias_en),
    .priv_low_en(priv_low_en), .priv_high_en(priv_high_en),
    .seg_base(seg_base), .seg_size(seg_size), .acc_addr(acc_addr),
    .acc_priv(acc_priv), .acc_we(acc_we), .mem_rdata(mem_rdata),
    .acc_rdata(acc_rdata), .mem_we(mem_we), .acc_blocked(acc_blocked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    chk(req, {28'b0, legacy_bus_en, high_alias_en, priv_low_en, priv_high_en}, {28'b0, exp});
  endtask

  // basic, extended, {legacy, alias, priv_low, priv_high}, size
  localparam logic [43:0] VECS [0:10] = '{
    {8'h00, 8'h00, 4'b1000, 24'h000000},
    {8'h01, 8'h80, 4'b0100, 24'h000000},
    {8'h01, 8'h00, 4'b1000, 24'h000000},
    {8'h02, 8'h00, 4'b1010, 24'h000000},
    {8'h02, 8'h80, 4'b1001, 24'h000000},
    {8'h03, 8'h81, 4'b0101, 24'h100000},
    {8'h03, 8'h03, 4'b1010, 24'h200000},
    {8'h00, 8'h05, 4'b1000, 24'h800000},
    {8'h00, 8'h07, 4'b1000, 24'h000000},
    {8'h00, 8'h04, 4'b1000, 24'h000000},
    {8'hF8, 8'h7F, 4'b1000, 24'h000000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
    tolm = 32'h8000_0000; acc_addr = 32'h0; acc_priv = 1'b0; acc_we = 1'b0;
    mem_rdata = 32'h1234_5678;
    do_reset();

    // R1 reset state
    chk("R1 basic", {24'b0, basic_q}, 32'h0);
    chk("R1 ext", {24'b0, ext_q}, 32'h0);
    chk_flags("R1 flags", 4'b1000);
    chk("R1 size", seg_size, 32'h0);

    // R5 R6 R7 R8 R9 R11 table
    for (int i = 0; i < 11; i++) begin
      wr(1'b0, VECS[i][43:36]);
      wr(1'b1, VECS[i][35:28]);
      chk("R11 basic readback", {24'b0, basic_q}, {24'b0, VECS[i][43:36] & 8'h07});
      chk("R11 ext readback", {24'b0, ext_q}, {24'b0, VECS[i][35:28] & 8'h87});
      chk_flags("R5 R6 R7 flags", VECS[i][27:24]);
      chk("R8 size", seg_size, {8'b0, VECS[i][23:0]});
      chk("R9 base", seg_base, 32'h8000_0000 - {8'b0, VECS[i][23:0]});
    end

    // R10 filter, 8 MiB segment below 0x8000_0000
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h05);
    acc_we = 1'b1;
    acc_addr = 32'h7F80_0000; #1;
    chk("R10 first word rdata", acc_rdata, 32'hFFFF_FFFF);
    chk("R10 first word we", {31'b0, mem_we}, 32'h0);
    chk("R10 first word blocked", {31'b0, acc_blocked}, 32'h1);
    acc_addr = 32'h7FFF_FFFC; #1;
    chk("R10 last word blocked", {31'b0, acc_blocked}, 32'h1);
    acc_addr = 32'h8000_0000; #1;
    chk("R10 above top rdata", acc_rdata, 32'h1234_5678);
    chk("R10 above top we", {31'b0, mem_we}, 32'h1);
    acc_addr = 32'h7F7F_FFFC; #1;
    chk("R10 below base blocked", {31'b0, acc_blocked}, 32'h0);
    acc_addr = 32'h7F80_0000; acc_priv = 1'b1; #1;
    chk("R10 privileged rdata", acc_rdata, 32'h1234_5678);
    chk("R10 privileged we", {31'b0, mem_we}, 32'h1);
    acc_priv = 1'b0; acc_we = 1'b0;

    // R9 moved top of memory
    tolm = 32'h4000_0000; #1;
    chk("R9 moved base", seg_base, 32'h3F80_0000);
    acc_addr = 32'h3F90_0000; #1;
    chk("R10 moved segment blocked", {31'b0, acc_blocked}, 32'h1);

    // R3 lock set together with open
    wr(1'b0, 8'h07);
    chk("R3 open cleared by lock", {24'b0, basic_q}, 32'h06);
    // R2 R4 writes while locked
    wr(1'b0, 8'h00);
    chk("R2 lock sticky", {24'b0, basic_q}, 32'h06);
    wr(1'b1, 8'h80);
    chk("R4 ext frozen", {24'b0, ext_q}, 32'h05);
    chk_flags("R4 flags frozen", 4'b1010);

    // R2 reset clears the lock
    do_reset();
    chk("R2 reset unlocks", {24'b0, basic_q}, 32'h0);
    // R3 lock after open
    wr(1'b0, 8'h01);
    chk("R3 open before lock", {24'b0, basic_q}, 32'h01);
    wr(1'b0, 8'h05);
    chk("R3 lock closes open", {24'b0, basic_q}, 32'h04);
    chk_flags("R6 closed after lock", 4'b1000);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule